// File: doc/BRIEF.md
# Interrupt Redirection Table Controller

This block routes external interrupt lines to interrupt messages. Each input line has one programmable routing entry. The entry sets the vector, the delivery mode, the destination mode, the destination ID, the active polarity, edge or level triggering, and a mask. The block watches every line. An event on an unmasked line turns into a message, which the block presents on a request/acknowledge output. Level-triggered entries use a remote-IRR handshake: after one message has been accepted, that entry stays silent until an end-of-interrupt carrying the entry's vector comes back.

Software never addresses a register directly. It first writes a register number into the index register at byte offset 0x00. It then reads or writes the data window at byte offset 0x10, and that access acts on the register whose number was last written.

The delivery engine is a two-state machine:
- **ST_IDLE**: no message is on the output. On any clock where an unmasked entry is pending, the lowest-numbered such entry is latched and the machine takes the transition **pick** to ST_OFFER.
- **ST_OFFER**: `msg_req` is held high with the latched fields. When `msg_ack` is seen, the machine takes the transition **accept** back to ST_IDLE. At that edge the entry's delivery status clears, and its remote IRR is set if the entry is level-triggered.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, every entry's low word reads 0x0001_0000 (only the mask bit set) and every high word reads 0. The ID register and the index register read 0, and `msg_req` is low.
- R2: A bus write at offset 0x00 loads bits 7:0 into the index register. A read at offset 0x00 returns the index in bits 7:0, with the upper bits zero. A data-window access at offset 0x10 acts on the register the index selects. Any other offset reads 0 and ignores writes.
- R3: Register number 0x00 is the ID register, with a writable ID in bits 31:24. Register number 0x01 reads (entry count − 1) in bits 23:16 and the version code 0x11 in bits 7:0, and writes to it are ignored.
- R4: Entry n's low word is at register number 0x10+2n and its high word at 0x10+2n+1. The high word keeps the destination in bits 31:24. The low word keeps the vector in bits 7:0, the delivery mode in 10:8, the destination mode in bit 11, the polarity in 13, the trigger mode in 15 and the mask in 16. Register numbers outside the ID register, the version register and the table read 0.
- R5: Bit 12 (delivery status) and bit 14 (remote IRR) of a low word ignore writes. Reserved bits (low word 31:17, high word 23:0) read 0.
- R6: On an unmasked edge-mode entry (bit 15 = 0), a transition of the line to its active level sets delivery status (bit 12). The status stays set until the message has been accepted. A transition that happens while the entry is masked is lost: clearing the mask later sends nothing. A transition to the inactive level sends nothing.
- R7: Polarity bit 13 = 1 makes the line active low. Bit 13 = 0 makes it active high.
- R8: While `msg_req` is high, the message fields (vector, delivery mode, destination mode, destination, trigger mode) hold steady until `msg_ack`. `msg_req` drops in the cycle after the acknowledge.
- R9: On an unmasked level-mode entry (bit 15 = 1), an active line sends one message, and remote IRR (bit 14) is set when that message is accepted. No further message goes out until `eoi_valid` arrives with `eoi_vector` equal to the entry's vector; an end-of-interrupt with another vector has no effect. If the line is still active when remote IRR clears, the message is sent again.
- R10: When several unmasked entries are pending at once, the lowest-numbered entry is offered first.
- R11: An entry that becomes masked while it is pending keeps its delivery status but is not offered. Clearing the mask then lets the message go out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Bus access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 5 | Byte offset (0x00 index, 0x10 data window) |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data (combinational on acc_addr and the index) |
| irq_pins | input | N_ENT | External interrupt lines |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt |
| msg_req | output | 1 | Message offered |
| msg_ack | input | 1 | Message accepted |
| msg_vector | output | 8 | Message vector |
| msg_dmode | output | 3 | Message delivery mode |
| msg_dest_mode | output | 1 | Message destination mode |
| msg_dest | output | 8 | Message destination ID |
| msg_level | output | 1 | Message comes from a level-mode entry |

## Verification
The hardest state to reach from the ports is an entry that is pending but masked. To get there, the stimulus holds one message unacknowledged so that the engine is busy, pulses a second line, and masks that entry through the window before it can be picked. Level resend is also hard to reach: the line must still be active at the exact point where a matching end-of-interrupt clears remote IRR, and a non-matching end-of-interrupt is sent first to show that it changes nothing. Random window writes with the read-only and reserved bits set at random are checked against a bench-side model of every table word.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    // Bit positions of the low configuration word
    localparam int unsigned LO_DSTAT = 12;
    localparam int unsigned LO_RIRR  = 14;
    localparam logic [31:0] LO_RW_MASK = 32'h0001_AFFF;

    typedef struct packed {
        logic       mask;
        logic       trig;      // 1 = level
        logic       pol;       // 1 = active low
        logic       dstmode;
        logic [2:0] dmode;
        logic [7:0] vector;
        logic [7:0] dest;
    } rte_cfg_t;

    typedef struct packed {
        logic [7:0] vector;
        logic [2:0] dmode;
        logic       dstmode;
        logic [7:0] dest;
        logic       level;
    } route_msg_t;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } dlv_state_t;

endpackage

// File: rtl/irq_rte_entry.sv
module irq_rte_entry
    import irq_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [31:0]       wdata,
    input  logic              pin,
    input  logic              eoi_valid,
    input  logic [7:0]        eoi_vector,
    input  logic              accepted,
    output rte_cfg_t          cfg,
    output logic              pend,
    output logic              rirr,
    output logic [31:0]       lo_word,
    output logic [31:0]       hi_word
);

    logic prev_act;
    logic act;
    logic set_edge;
    logic set_level;
    logic eoi_hit;
    logic wdata_unused;

    assign wdata_unused = ^{wdata[23:17], wdata[14], wdata[12]};

    assign act       = pin ^ cfg.pol;
    assign set_edge  = !cfg.trig && !cfg.mask && act && !prev_act;
    assign set_level = cfg.trig && !cfg.mask && act && !rirr && !pend;
    assign eoi_hit   = eoi_valid && cfg.trig && rirr && (eoi_vector == cfg.vector);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg      <= '0;
            cfg.mask <= 1'b1;
            pend     <= 1'b0;
            rirr     <= 1'b0;
            prev_act <= 1'b0;
        end else begin
            prev_act <= act;
            if (wr_lo) begin
                cfg.vector  <= wdata[7:0];
                cfg.dmode   <= wdata[10:8];
                cfg.dstmode <= wdata[11];
                cfg.pol     <= wdata[13];
                cfg.trig    <= wdata[15];
                cfg.mask    <= wdata[16];
            end
            if (wr_hi) begin
                cfg.dest <= wdata[31:24];
            end
            if (accepted) begin
                pend <= 1'b0;
            end
            if (set_edge || set_level) begin
                pend <= 1'b1;
            end
            if (accepted && cfg.trig) begin
                rirr <= 1'b1;
            end else if (eoi_hit) begin
                rirr <= 1'b0;
            end
        end
    end

    assign lo_word = {15'b0, cfg.mask, cfg.trig, rirr, cfg.pol, pend,
                      cfg.dstmode, cfg.dmode, cfg.vector};
    assign hi_word = {cfg.dest, 24'b0};

endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int unsigned N  = 24,
    parameter int unsigned IW = 5
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IW'(i);
            end
        end
    end

    assign any = |req;

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int unsigned N_ENT    = 24,
    parameter logic [7:0]  VER_CODE = 8'h11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [4:0]        acc_addr,
    input  logic [31:0]       acc_wdata,
    output logic [31:0]       acc_rdata,
    input  logic [N_ENT-1:0]  irq_pins,
    input  logic              eoi_valid,
    input  logic [7:0]        eoi_vector,
    output logic              msg_req,
    input  logic              msg_ack,
    output logic [7:0]        msg_vector,
    output logic [2:0]        msg_dmode,
    output logic              msg_dest_mode,
    output logic [7:0]        msg_dest,
    output logic              msg_level
);

    localparam int unsigned IW       = (N_ENT > 1) ? $clog2(N_ENT) : 1;
    localparam logic [7:0]  TAB_BASE = 8'h10;
    localparam logic [7:0]  TAB_LAST = 8'(16 + 2 * N_ENT - 1);
    localparam logic [7:0]  MAX_ENT  = 8'(N_ENT - 1);

    logic [7:0]  index_q;
    logic [7:0]  id_q;
    logic        sel_idx_reg;
    logic        sel_data;
    logic        wr_data;

    rte_cfg_t    cfg_arr [N_ENT];
    logic [31:0] lo_arr  [N_ENT];
    logic [31:0] hi_arr  [N_ENT];
    logic [N_ENT-1:0] pend_v;
    logic [N_ENT-1:0] rirr_v;
    logic [N_ENT-1:0] mask_v;
    logic [N_ENT-1:0] cand_v;

    dlv_state_t  state_q, state_d;
    logic [IW-1:0] sel_q;
    logic [IW-1:0] pick_idx;
    logic          pick_any;
    route_msg_t    msg_q;
    logic [31:0]   win_rdata;

    assign sel_idx_reg = (acc_addr == 5'h00);
    assign sel_data    = (acc_addr == 5'h10);
    assign wr_data     = acc_valid && acc_write && sel_data;

    // Index and ID registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q <= '0;
            id_q    <= '0;
        end else begin
            if (acc_valid && acc_write && sel_idx_reg) begin
                index_q <= acc_wdata[7:0];
            end
            if (wr_data && index_q == 8'h00) begin
                id_q <= acc_wdata[31:24];
            end
        end
    end

    // Routing entries
    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        localparam logic [7:0] LO_IX = 8'(16 + 2 * g);
        localparam logic [7:0] HI_IX = 8'(16 + 2 * g + 1);
        logic accepted_g;

        assign accepted_g = (state_q == ST_OFFER) && msg_ack && (sel_q == IW'(g));

        irq_rte_entry u_ent (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_lo      (wr_data && index_q == LO_IX),
            .wr_hi      (wr_data && index_q == HI_IX),
            .wdata      (acc_wdata),
            .pin        (irq_pins[g]),
            .eoi_valid  (eoi_valid),
            .eoi_vector (eoi_vector),
            .accepted   (accepted_g),
            .cfg        (cfg_arr[g]),
            .pend       (pend_v[g]),
            .rirr       (rirr_v[g]),
            .lo_word    (lo_arr[g]),
            .hi_word    (hi_arr[g])
        );
        assign mask_v[g] = cfg_arr[g].mask;
    end

    assign cand_v = pend_v & ~mask_v;

    irq_lowest_pick #(.N(N_ENT), .IW(IW)) u_pick (
        .req (cand_v),
        .any (pick_any),
        .idx (pick_idx)
    );

    // Read path
    always_comb begin
        win_rdata = '0;
        if (index_q == 8'h00) begin
            win_rdata = {id_q, 24'b0};
        end else if (index_q == 8'h01) begin
            win_rdata = {8'b0, MAX_ENT, 8'b0, VER_CODE};
        end else if (index_q >= TAB_BASE && index_q <= TAB_LAST) begin
            if (index_q[0]) begin
                win_rdata = hi_arr[IW'((index_q - TAB_BASE) >> 1)];
            end else begin
                win_rdata = lo_arr[IW'((index_q - TAB_BASE) >> 1)];
            end
        end
    end

    assign acc_rdata = sel_idx_reg ? {24'b0, index_q} :
                       sel_data    ? win_rdata : 32'b0;

    // Delivery state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (pick_any) state_d = ST_OFFER;
            ST_OFFER: if (msg_ack)  state_d = ST_IDLE;
        endcase
    end

    // Message latch on the pick transition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            msg_q <= '0;
        end else if (state_q == ST_IDLE && pick_any) begin
            sel_q         <= pick_idx;
            msg_q.vector  <= cfg_arr[pick_idx].vector;
            msg_q.dmode   <= cfg_arr[pick_idx].dmode;
            msg_q.dstmode <= cfg_arr[pick_idx].dstmode;
            msg_q.dest    <= cfg_arr[pick_idx].dest;
            msg_q.level   <= cfg_arr[pick_idx].trig;
        end
    end

    // Outputs
    always_comb begin
        msg_req       = (state_q == ST_OFFER);
        msg_vector    = msg_q.vector;
        msg_dmode     = msg_q.dmode;
        msg_dest_mode = msg_q.dstmode;
        msg_dest      = msg_q.dest;
        msg_level     = msg_q.level;
    end

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
    parameter int unsigned N = 24
) (
    input logic         clk,
    input logic         rst_n,
    input logic         msg_req,
    input logic         msg_ack,
    input logic [7:0]   msg_vector,
    input logic [7:0]   msg_dest,
    input logic [N-1:0] pend_v,
    input logic [N-1:0] rirr_v,
    input logic [N-1:0] mask_v
);

    a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        msg_req && !msg_ack |=> msg_req && $stable(msg_vector) && $stable(msg_dest));

    a_r8_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        msg_req && msg_ack |=> !msg_req);

    a_r9_rirr_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rirr_v & ~$past(rirr_v))) |-> $past(msg_req && msg_ack));

    a_r6_pend_clears_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend_v & ~$past(pend_v) ^ pend_v & ~$past(pend_v))) ||
        !(|(~pend_v & $past(pend_v))) || $past(msg_req && msg_ack));

    a_r10_one_clear_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~pend_v & $past(pend_v)));

    a_r11_offer_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_req) |-> $past(|(pend_v & ~mask_v)));

endmodule

bind irq_route_ctrl irq_route_chk #(.N(N_ENT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .msg_req    (msg_req),
    .msg_ack    (msg_ack),
    .msg_vector (msg_vector),
    .msg_dest   (msg_dest),
    .pend_v     (pend_v),
    .rirr_v     (rirr_v),
    .mask_v     (mask_v)
);

// File: tb/irq_route_ctrl_test.sv
module irq_route_ctrl_test;

    localparam int N = 24;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_valid, acc_write;
    logic [4:0]  acc_addr;
    logic [31:0] acc_wdata, acc_rdata;
    logic [N-1:0] pins;
    logic        eoi_valid;
    logic [7:0]  eoi_vector;
    logic        msg_req, msg_ack;
    logic [7:0]  msg_vector, msg_dest;
    logic [2:0]  msg_dmode;
    logic        msg_dest_mode, msg_level;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] mdl [2*N];

    always #5 clk = ~clk;

    irq_route_ctrl #(.N_ENT(N)) uut (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .irq_pins(pins), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .msg_req(msg_req), .msg_ack(msg_ack), .msg_vector(msg_vector),
        .msg_dmode(msg_dmode), .msg_dest_mode(msg_dest_mode),
        .msg_dest(msg_dest), .msg_level(msg_level)
    );

    function automatic logic [31:0] exp_lo(input logic [31:0] d);
        return d & 32'h0001_AFFF;
    endfunction

    function automatic logic [31:0] exp_hi(input logic [31:0] d);
        return d & 32'hFF00_0000;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic win_wr(input logic [7:0] ix, input logic [31:0] d);
        bus_wr(5'h00, {24'b0, ix});
        bus_wr(5'h10, d);
    endtask

    task automatic win_rd(input logic [7:0] ix, output logic [31:0] d);
        bus_wr(5'h00, {24'b0, ix});
        acc_addr = 5'h10;
        #1 d = acc_rdata;
    endtask

    task automatic wait_req(input int lim, output logic got);
        int k;
        got = 1'b0;
        k = 0;
        while (k < lim && !got) begin
            if (msg_req) got = 1'b1;
            else begin
                @(negedge clk);
                k++;
            end
        end
    endtask

    task automatic ack1();
        msg_ack = 1'b1;
        @(negedge clk);
        msg_ack = 1'b0;
    endtask

    task automatic send_eoi(input logic [7:0] v);
        eoi_valid = 1'b1; eoi_vector = v;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic got;
        void'($urandom(32'h5EED_0421));
        rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0;
        acc_wdata = '0; pins = '0; eoi_valid = 1'b0; eoi_vector = '0; msg_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "msg_req", {31'b0, msg_req}, 32'h0);
        acc_addr = 5'h00; #1 chk("R1", "index", acc_rdata, 32'h0);
        win_rd(8'h10, rd); chk("R1", "entry0 lo", rd, 32'h0001_0000);
        win_rd(8'h10 + 8'd47, rd); chk("R1", "entry23 hi", rd, 32'h0);
        win_rd(8'h00, rd); chk("R1", "id", rd, 32'h0);

        // R3 ID and version
        win_rd(8'h01, rd); chk("R3", "version", rd, 32'h0017_0011);
        win_wr(8'h01, 32'hFFFF_FFFF);
        win_rd(8'h01, rd); chk("R3", "version ro", rd, 32'h0017_0011);
        win_wr(8'h00, 32'hFFFF_FFFF);
        win_rd(8'h00, rd); chk("R3", "id rw", rd, 32'hFF00_0000);

        // R2 index register and offsets
        bus_wr(5'h00, 32'h0001_2345);
        acc_addr = 5'h00; #1 chk("R2", "index 8 bits", acc_rdata, 32'h45);
        bus_wr(5'h04, 32'h0000_0099);
        acc_addr = 5'h04; #1 chk("R2", "other offset", acc_rdata, 32'h0);
        acc_addr = 5'h00; #1 chk("R2", "index unchanged", acc_rdata, 32'h45);

        // R4 out-of-map indices
        win_rd(8'h02, rd); chk("R4", "idx 2", rd, 32'h0);
        win_rd(8'h40, rd); chk("R4", "past table", rd, 32'h0);

        // R4 R5 random window writes (mask kept set so no line fires)
        for (int k = 0; k < 2 * N; k++) mdl[k] = (k % 2 == 0) ? 32'h0001_0000 : 32'h0;
        for (int it = 0; it < 200; it++) begin
            int k;
            logic [31:0] d;
            k = int'($urandom % (2 * N));
            d = $urandom;
            if (k % 2 == 0) begin
                d = d | 32'h0001_0000;
                mdl[k] = exp_lo(d);
            end else begin
                mdl[k] = exp_hi(d);
            end
            win_wr(8'(16 + k), d);
            if (it % 8 == 0) begin
                int j;
                j = int'($urandom % (2 * N));
                win_rd(8'(16 + j), rd);
                chk("R5", "random readback", rd, mdl[j]);
            end
        end
        for (int k = 0; k < 2 * N; k++) begin
            win_rd(8'(16 + k), rd);
            chk("R4", "table word", rd, mdl[k]);
        end
        for (int k = 0; k < N; k++) begin
            win_wr(8'(16 + 2 * k), 32'h0001_0000);
            win_wr(8'(17 + 2 * k), 32'h0);
        end

        // R6 R8 edge entry 3
        win_wr(8'h17, 32'h0500_0000);
        win_wr(8'h16, 32'h0000_0233);
        pins[3] = 1'b1;
        wait_req(20, got);
        chk("R6", "edge sent", {31'b0, got}, 32'h1);
        chk("R8", "vector", {24'b0, msg_vector}, 32'h33);
        chk("R8", "dest", {24'b0, msg_dest}, 32'h05);
        chk("R8", "dmode", {29'b0, msg_dmode}, 32'h2);
        chk("R8", "level flag", {31'b0, msg_level}, 32'h0);
        repeat (4) @(negedge clk);
        chk("R8", "req held", {31'b0, msg_req}, 32'h1);
        chk("R8", "vector held", {24'b0, msg_vector}, 32'h33);
        win_rd(8'h16, rd); chk("R6", "delivery status set", rd, 32'h0000_1233);
        ack1();
        chk("R8", "req dropped", {31'b0, msg_req}, 32'h0);
        win_rd(8'h16, rd); chk("R6", "delivery status clear", rd, 32'h0000_0233);
        pins[3] = 1'b0;
        wait_req(10, got);
        chk("R6", "falling edge silent", {31'b0, got}, 32'h0);

        // R6 masked transition dropped (entry 4)
        win_wr(8'h18, 32'h0001_0044);
        pins[4] = 1'b1; repeat (2) @(negedge clk); pins[4] = 1'b0;
        win_wr(8'h18, 32'h0000_0044);
        wait_req(15, got);
        chk("R6", "masked edge dropped", {31'b0, got}, 32'h0);

        // R7 active-low entry 5
        pins[5] = 1'b1;
        win_wr(8'h1A, 32'h0001_2055);
        win_wr(8'h1A, 32'h0000_2055);
        wait_req(10, got);
        chk("R7", "high idle silent", {31'b0, got}, 32'h0);
        pins[5] = 1'b0;
        wait_req(20, got);
        chk("R7", "falling fires", {31'b0, got}, 32'h1);
        chk("R7", "vector", {24'b0, msg_vector}, 32'h55);
        ack1();
        pins[5] = 1'b1;
        wait_req(10, got);
        chk("R7", "rising silent", {31'b0, got}, 32'h0);

        // R10 priority entries 2 and 6
        win_wr(8'h14, 32'h0000_0022);
        win_wr(8'h1C, 32'h0000_0066);
        pins[2] = 1'b1; pins[6] = 1'b1;
        wait_req(20, got);
        chk("R10", "first is lowest", {24'b0, msg_vector}, 32'h22);
        ack1();
        wait_req(20, got);
        chk("R10", "second follows", {23'b0, got, msg_vector}, 32'h166);
        ack1();
        pins[2] = 1'b0; pins[6] = 1'b0;

        // R9 level entry 7
        win_wr(8'h1E, 32'h0000_8077);
        pins[7] = 1'b1;
        wait_req(20, got);
        chk("R9", "level sent", {23'b0, got, msg_vector}, 32'h177);
        chk("R9", "level flag", {31'b0, msg_level}, 32'h1);
        ack1();
        wait_req(10, got);
        chk("R9", "no repeat before eoi", {31'b0, got}, 32'h0);
        win_rd(8'h1E, rd); chk("R9", "remote irr set", rd, 32'h0000_C077);
        send_eoi(8'h12);
        wait_req(8, got);
        chk("R9", "foreign eoi ignored", {31'b0, got}, 32'h0);
        win_rd(8'h1E, rd); chk("R9", "remote irr kept", rd, 32'h0000_C077);
        send_eoi(8'h77);
        wait_req(20, got);
        chk("R9", "resend while active", {23'b0, got, msg_vector}, 32'h177);
        ack1();
        pins[7] = 1'b0;
        send_eoi(8'h77);
        wait_req(8, got);
        chk("R9", "inactive no resend", {31'b0, got}, 32'h0);
        win_rd(8'h1E, rd); chk("R9", "remote irr cleared", rd, 32'h0000_8077);

        // R11 pending entry masked while engine busy
        win_wr(8'h20, 32'h0000_0088);
        pins[3] = 1'b1;
        wait_req(20, got);
        chk("R11", "blocker offered", {23'b0, got, msg_vector}, 32'h133);
        pins[8] = 1'b1; @(negedge clk); pins[8] = 1'b0;
        win_wr(8'h20, 32'h0001_0088);
        ack1();
        wait_req(10, got);
        chk("R11", "masked pending held back", {31'b0, got}, 32'h0);
        win_rd(8'h20, rd); chk("R11", "status kept", rd, 32'h0001_1088);
        win_wr(8'h20, 32'h0000_0088);
        wait_req(20, got);
        chk("R11", "released after unmask", {23'b0, got, msg_vector}, 32'h188);
        ack1();
        pins[3] = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule